// File: doc/BRIEF.md
# Bit-serial CRC-8 generator and checker

This block computes an 8-bit cyclic redundancy code one bit at a time over the protected part of a serial frame. The protected part runs from the 4-bit priority field, through the length, destination, message identifier and data bytes. The generator polynomial is x^8+x^4+x+1, the register starts at zero, and no final inversion is applied. The start-of-frame bit, stuffed bits and every field after the code are never presented. The caller feeds bits that have already been destuffed, most significant bit of each field first, each marked by a valid strobe.

In generate mode the caller presents the frame bits. The 8-bit remainder is then the code to append. In check mode the caller also presents the 8 received code bits. A correct frame leaves a remainder of zero. The caller then raises a done strobe, which latches a pass flag.

The register uses the direct (Galois) form. It gives the same result as long division with eight appended zero bits, without spending eight extra cycles on them. A clear pulse at the start of each frame returns the register to zero.

Top module: `crc8_serial`

## Requirements
- R1: While `rst` is high at a rising edge, `crc_out` becomes 0x00 and `crc_ok` becomes 0.
- R2: A `frame_clr` pulse sets `crc_out` to 0x00 and `crc_ok` to 0 at the next edge. A bit strobed in the same cycle is discarded.
- R3: Each cycle with `bit_vld` high and `frame_clr` low shifts `bit_in` into the remainder, and `crc_out` shows the result after that edge. A cycle without `bit_vld` leaves `crc_out` unchanged.
- R4: After the protected bits are fed MSB first from a cleared state, `crc_out` equals the code for polynomial 0x113 with a zero start and no final XOR. Expected results:
  - bytes 53 D2 C8 00 give E9;
  - bytes 63 D2 2C 00 give B5;
  - bytes 64 98 CC 02 A7 give D4;
  - the single byte 05 gives 5F;
  - bytes 53 D2 give 14.
- R5: Feeding a frame followed by its correct code byte leaves `crc_out` at 0x00. A frame with one corrupted bit leaves it nonzero.
- R6: `chk_done` with `chk_mode`=1 (check) sets `crc_ok` to 1 when the remainder held at that edge is zero, and to 0 otherwise. That remainder excludes any bit strobed in the same cycle.
- R7: `chk_done` with `chk_mode`=0 (generate) sets `crc_ok` to 0.
- R8: Without `chk_done`, `frame_clr` or `rst`, `crc_ok` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_clr | input | 1 | Start-of-frame clear pulse |
| bit_vld | input | 1 | Strobe marking a destuffed data bit |
| bit_in | input | 1 | Data bit, MSB of each field first |
| chk_mode | input | 1 | 0 = generate, 1 = check |
| chk_done | input | 1 | Strobe that latches the pass verdict |
| crc_out | output | 8 | Current remainder (the code in generate mode) |
| crc_ok | output | 1 | Latched verdict: remainder was zero in check mode |

## Verification
The bench goes after several corner cases:
- **Clear and bit in one cycle.** A design that let the bit in would start the next frame with a nonzero remainder, and every later code would be wrong.
- **Done strobe and bit in one cycle.** This shows whether the verdict uses the remainder before that bit; a design using the later value would report a stale pass or fail.
- **Gaps between strobes.** A register that shifted without a strobe would drift.
- **Done strobe in generate mode.** A design ignoring the mode would report a pass there.
- **Known codes and corrupted frames.** Known codes catch a wrong polynomial, a reversed bit order or a leftover final XOR. A single flipped bit must clear the flag.

// File: rtl/crc8_serial_pkg.sv
package crc8_serial_pkg;
  localparam int unsigned CRC_W = 8;
  localparam logic [CRC_W:0] GEN_POLY = 9'h113;
  typedef enum logic {MODE_GEN = 1'b0, MODE_CHK = 1'b1} crc_mode_e;
endpackage

// File: rtl/crc8_lfsr_next.sv
module crc8_lfsr_next #(
  parameter int unsigned W = 8,
  parameter logic [W:0] POLY = 9'h113
) (
  input  logic [W-1:0] cur,
  input  logic         din,
  output logic [W-1:0] nxt
);
  logic fb;
  assign fb = cur[W-1] ^ din;

  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == 0) begin : g_lsb
      assign nxt[0] = POLY[0] & fb;
    end else begin : g_mid
      assign nxt[i] = cur[i-1] ^ (POLY[i] & fb);
    end
  end
endmodule

// File: rtl/crc8_rem_reg.sv
module crc8_rem_reg #(
  parameter int unsigned W = 8,
  parameter logic [W:0] POLY = 9'h113
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         bit_vld,
  input  logic         bit_in,
  output logic [W-1:0] rem_q
);
  logic [W-1:0] rem_nxt;

  crc8_lfsr_next #(.W(W), .POLY(POLY)) u_next (
    .cur (rem_q),
    .din (bit_in),
    .nxt (rem_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) rem_q <= '0;
    else if (bit_vld) rem_q <= rem_nxt;
  end

  // R1
  rst_zero_chk: assert property (@(posedge clk) rst |=> (rem_q == '0));
  // R2
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst) clr |=> (rem_q == '0));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !bit_vld) |=> $stable(rem_q));
endmodule

// File: rtl/crc8_verdict.sv
module crc8_verdict #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         chk_done,
  input  logic         mode,
  input  logic [W-1:0] rem,
  output logic         ok_q
);
  import crc8_serial_pkg::*;
  crc_mode_e mode_e;
  assign mode_e = crc_mode_e'(mode);

  always_ff @(posedge clk) begin
    if (rst || clr) ok_q <= 1'b0;
    else if (chk_done) ok_q <= (mode_e == MODE_CHK) && (rem == '0);
  end

  // R6
  pass_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_done && mode && !clr && rem == '0) |=> ok_q);
  // R6
  fail_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_done && !clr && rem != '0) |=> !ok_q);
  // R7
  gen_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_done && !mode) |=> !ok_q);
  // R8
  ok_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!chk_done && !clr) |=> $stable(ok_q));
endmodule

// File: rtl/crc8_serial.sv
module crc8_serial
  import crc8_serial_pkg::*;
#(
  parameter int unsigned W = CRC_W,
  parameter logic [W:0] POLY = GEN_POLY
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_clr,
  input  logic         bit_vld,
  input  logic         bit_in,
  input  logic         chk_mode,
  input  logic         chk_done,
  output logic [W-1:0] crc_out,
  output logic         crc_ok
);
  logic [W-1:0] rem;

  crc8_rem_reg #(.W(W), .POLY(POLY)) u_rem (
    .clk     (clk),
    .rst     (rst),
    .clr     (frame_clr),
    .bit_vld (bit_vld),
    .bit_in  (bit_in),
    .rem_q   (rem)
  );

  crc8_verdict #(.W(W)) u_verdict (
    .clk      (clk),
    .rst      (rst),
    .clr      (frame_clr),
    .chk_done (chk_done),
    .mode     (chk_mode),
    .rem      (rem),
    .ok_q     (crc_ok)
  );

  assign crc_out = rem;
endmodule

// File: tb/crc8_serial_bench.sv
module crc8_serial_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_clr = 1'b0, bit_vld = 1'b0, bit_in = 1'b0;
  logic chk_mode = 1'b0, chk_done = 1'b0;
  logic [7:0] crc_out;
  logic crc_ok;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc8_serial u_crc8_serial (
    .clk(clk), .rst(rst), .frame_clr(frame_clr), .bit_vld(bit_vld),
    .bit_in(bit_in), .chk_mode(chk_mode), .chk_done(chk_done),
    .crc_out(crc_out), .crc_ok(crc_ok)
  );

  // Reference: long division of the stored bits plus eight zero bits
  bit q[$];
  int exp_ok = 0;

  function automatic int divide(bit bits[$]);
    int r = 0;
    for (int i = 0; i < bits.size() + 8; i++) begin
      r = (r << 1) | ((i < bits.size()) ? int'(bits[i]) : 0);
      if (r & 'h100) r = r ^ 'h113;
    end
    return r & 'hFF;
  endfunction

  always @(posedge clk) begin
    if (rst || frame_clr) begin
      q.delete();
      exp_ok = 0;
    end else begin
      if (chk_done) exp_ok = (chk_mode && divide(q) == 0) ? 1 : 0;
      if (bit_vld) q.push_back(bit_in);
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison (R3 remainder tracking, R8 flag holding)
  always @(negedge clk) begin
    if (!finished) begin
      check("R3 remainder", int'(crc_out), divide(q));
      check("R8 flag", int'(crc_ok), exp_ok);
    end
  end

  task automatic send_bit(bit b);
    bit_vld = 1'b1; bit_in = b;
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic clear();
    frame_clr = 1'b1;
    @(negedge clk);
    frame_clr = 1'b0;
  endtask

  task automatic done();
    chk_done = 1'b1;
    @(negedge clk);
    chk_done = 1'b0;
  endtask

  task automatic known(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2,
                       logic [7:0] b3, logic [7:0] b4, int n, int exp_crc);
    logic [7:0] bs [5];
    bs = '{b0, b1, b2, b3, b4};
    clear();
    chk_mode = 1'b0;
    for (int i = 0; i < n; i++) send_byte(bs[i]);
    check("R4 known code", int'(crc_out), exp_crc);
    chk_mode = 1'b1;
    send_byte(crc_out);
    check("R5 residue zero", int'(crc_out), 0);
    done();
    check("R6 pass flag", int'(crc_ok), 1);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 reset crc", int'(crc_out), 0);
    check("R1 reset ok", int'(crc_ok), 0);
    rst = 1'b0;
    @(negedge clk);

    known(8'h53, 8'hD2, 8'hC8, 8'h00, 8'h00, 4, 'hE9);
    known(8'h63, 8'hD2, 8'h2C, 8'h00, 8'h00, 4, 'hB5);
    known(8'h64, 8'h98, 8'hCC, 8'h02, 8'hA7, 5, 'hD4);
    known(8'h05, 8'h00, 8'h00, 8'h00, 8'h00, 1, 'h5F);
    known(8'h53, 8'hD2, 8'h00, 8'h00, 8'h00, 2, 'h14);

    // R7: done in generate mode clears the flag
    chk_mode = 1'b0;
    done();
    check("R7 gen mode flag", int'(crc_ok), 0);

    // R2: clear with a simultaneous bit discards the bit
    send_byte(8'hA5);
    frame_clr = 1'b1; bit_vld = 1'b1; bit_in = 1'b1;
    @(negedge clk);
    frame_clr = 1'b0; bit_vld = 1'b0;
    check("R2 clear wins", int'(crc_out), 0);

    // R5: corrupted frame fails
    chk_mode = 1'b1;
    send_byte(8'h53); send_byte(8'hD2); send_byte(8'hC8); send_byte(8'h01);
    send_byte(8'hE9);
    check("R5 corrupt nonzero", int'(crc_out != 0), 1);
    done();
    check("R6 fail flag", int'(crc_ok), 0);

    // R6: done with a same-cycle bit uses the prior remainder
    clear();
    send_byte(8'h05); send_byte(8'h5F);
    chk_done = 1'b1; bit_vld = 1'b1; bit_in = 1'b1;
    @(negedge clk);
    chk_done = 1'b0; bit_vld = 1'b0;
    check("R6 prior remainder", int'(crc_ok), 1);

    // Random frames with gaps, both modes, random corruption
    for (int k = 0; k < 60; k++) begin
      int nb;
      logic [7:0] code;
      bit bad;
      clear();
      chk_mode = 1'b0;
      nb = 2 + ($urandom % 12);
      for (int j = 0; j < nb; j++) begin
        for (int i = 7; i >= 0; i--) begin
          send_bit(1'($urandom));
          if (($urandom % 4) == 0) @(negedge clk);
        end
      end
      code = crc_out;
      bad = (($urandom % 3) == 0);
      chk_mode = 1'($urandom % 4 != 0);
      send_byte(bad ? (code ^ 8'h10) : code);
      done();
      check("R6 random verdict", int'(crc_ok), (chk_mode && !bad) ? 1 : 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    finished = 1;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule